// File: doc/BRIEF.md
# Pipelined Converter Digital Correction Back End

This block is the digital half of a pipelined analog-to-digital converter. On every sampling clock it takes one raw 2-bit decision from each of nine sub-converter stages. Eight front stages each resolve one bit plus one redundant bit, and a last stage is a plain 2-bit flash. Because the stages work on alternating clock phases, the decisions for a single input sample reach the block spread over several cycles. The block delays each stage's stream by just enough to line them all up. It then adds the overlapping decisions with binary weights, which absorbs comparator errors in the front stages, and produces a 10-bit word.

The word can be presented as offset binary or as two's complement. It passes through a two-register output buffer, so each sample's result leaves the block a fixed number of clocks after the sample was taken. A warm-up flag holds the outputs at zero for a fixed number of clocks after reset. A drive-enable output tells the pad ring when it may drive the data bus.

Top module: `adc_correct_backend`

## Requirements
- R1: The result for a sample appears on `data_out` after the 7th rising clock edge, counted from the edge that captures that sample's stage-0 decision. A new result follows on every later edge.
- R2: `stage_code` carries stage k (k = 0 for the first stage through 8 for the flash stage) in bits [2k+1:2k]. The decision of stage k for a given sample arrives floor(k/2) cycles after that sample's stage-0 decision, and the block combines only decisions that belong to the same sample.
- R3: The result equals the sum over k = 0..7 of d_k·2^(8−k), plus the stage-8 code with weight 1. Here d_k is the stage-k decision, 0 to 2, so the result covers 0 to 1023.
- R4: A front-stage decision of 3 is illegal. It is summed as 2, and `range_err` is high with that sample's result. `range_err` is low for a result whose front decisions were all legal.
- R5: With `fmt_twos` low the result is offset binary. With it high, bit 9 of the result is inverted (two's complement). `fmt_twos` is sampled at the edge one cycle before the result appears.
- R6: `data_drive` is the inverse of `hiz_req` in the same cycle. The pad ring must float the data bus whenever `data_drive` is low.
- R7: After reset is released, `valid` is low until the 20th rising edge, then high, and it stays high until the next reset. While `valid` is low, `data_out` and `range_err` read zero.
- R8: While reset is held, `valid`, `data_out` and `range_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| stage_code | input | 18 | Raw 2-bit decisions of the nine stages, stage k in bits [2k+1:2k] |
| fmt_twos | input | 1 | Output format: 0 offset binary, 1 two's complement |
| hiz_req | input | 1 | Request to float the data bus |
| data_out | output | 10 | Corrected conversion result |
| data_drive | output | 1 | Drive enable for the data pads, low when floating |
| range_err | output | 1 | An illegal front-stage decision was seen in this sample |
| valid | output | 1 | Warm-up over, outputs carry results |

## Verification
Assertions check the following on every cycle: an illegal aligned decision yields a flagged word one cycle later and a legal set yields none, the second output register copies the first, the warm-up counter never passes its limit, `valid` never drops once it has risen, and the outputs are zero while `valid` is low. Only the bench's scenarios can show the things that depend on a whole sample's history. These are correct per-stage skew alignment, the exact weighted sum, the seven-cycle latency, and the one-cycle-early sampling of the format input. The bench shows them with directed extreme words, random streams with injected illegal decisions, and format and float changes in the middle of a stream.

// File: rtl/adc_be_pkg.sv
package adc_be_pkg;

    localparam int N_FRONT  = 8;
    localparam int N_STAGES = N_FRONT + 1;
    localparam int CODE_W   = 2;
    localparam int IN_W     = N_STAGES * CODE_W;
    localparam int RES_W    = N_FRONT + 2;
    localparam int MAX_SKEW = (N_STAGES - 1) / 2;
    localparam int LATENCY  = MAX_SKEW + 3;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic [RES_W-1:0] val;
        logic             err;
    } word_t;

    function automatic code_t clamp_code(input code_t c);
        return (c == 2'd3) ? 2'd2 : c;
    endfunction

    function automatic int stage_skew(input int k);
        return k / 2;
    endfunction

endpackage

// File: rtl/adc_skew_align.sv
module adc_skew_align
    import adc_be_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [IN_W-1:0] raw,
    output logic [IN_W-1:0] aligned
);

    for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
        localparam int DEPTH = 1 + MAX_SKEW - stage_skew(k);
        code_t line [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int j = 0; j < DEPTH; j++) line[j] <= '0;
            end else begin
                line[0] <= raw[CODE_W*k +: CODE_W];
                for (int j = 1; j < DEPTH; j++) line[j] <= line[j-1];
            end
        end

        assign aligned[CODE_W*k +: CODE_W] = line[DEPTH-1];
    end

endmodule

// File: rtl/adc_redundancy_merge.sv
module adc_redundancy_merge
    import adc_be_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [IN_W-1:0] aligned,
    output word_t           corr
);

    logic [RES_W:0] acc;
    logic           bad;

    always_comb begin
        acc = '0;
        bad = 1'b0;
        for (int i = 0; i < N_FRONT; i++) begin
            acc = acc + ((RES_W+1)'(clamp_code(aligned[CODE_W*i +: CODE_W])) << (N_FRONT - i));
            bad = bad | (aligned[CODE_W*i +: CODE_W] == 2'd3);
        end
        acc = acc + (RES_W+1)'(aligned[CODE_W*N_FRONT +: CODE_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            corr <= '0;
        end else begin
            corr.val <= acc[RES_W-1:0];
            corr.err <= bad;
        end
    end

    logic any_three;
    always_comb begin
        any_three = 1'b0;
        for (int i = 0; i < N_FRONT; i++)
            if (aligned[CODE_W*i +: CODE_W] == 2'd3) any_three = 1'b1;
    end

    assert_illegal_flag_R4: assert property (@(posedge clk) disable iff (rst)
        any_three |=> corr.err);

    assert_legal_clean_R4: assert property (@(posedge clk) disable iff (rst)
        !any_three |=> !corr.err);

endmodule

// File: rtl/adc_out_format.sv
module adc_out_format
    import adc_be_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t corr,
    input  logic  fmt_twos,
    output word_t held
);

    word_t stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            held   <= '0;
        end else begin
            stage1.val <= {corr.val[RES_W-1] ^ fmt_twos, corr.val[RES_W-2:0]};
            stage1.err <= corr.err;
            held       <= stage1;
        end
    end

    assert_double_buffer_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> held == $past(stage1));

endmodule

// File: rtl/adc_correct_backend.sv
module adc_correct_backend
    import adc_be_pkg::*;
#(
    parameter int VALID_CYCLES = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  stage_code,
    input  logic             fmt_twos,
    input  logic             hiz_req,
    output logic [RES_W-1:0] data_out,
    output logic             data_drive,
    output logic             range_err,
    output logic             valid
);

    localparam int CNT_W = $clog2(VALID_CYCLES + 1);

    logic [IN_W-1:0] aligned;
    word_t           corr;
    word_t           held;
    logic [CNT_W-1:0] warm_cnt;

    adc_skew_align u_align (
        .clk     (clk),
        .rst     (rst),
        .raw     (stage_code),
        .aligned (aligned)
    );

    adc_redundancy_merge u_merge (
        .clk     (clk),
        .rst     (rst),
        .aligned (aligned),
        .corr    (corr)
    );

    adc_out_format u_fmt (
        .clk      (clk),
        .rst      (rst),
        .corr     (corr),
        .fmt_twos (fmt_twos),
        .held     (held)
    );

    always_ff @(posedge clk) begin
        if (rst)
            warm_cnt <= '0;
        else if (warm_cnt != CNT_W'(VALID_CYCLES))
            warm_cnt <= warm_cnt + 1'b1;
    end

    assign valid      = (warm_cnt == CNT_W'(VALID_CYCLES));
    assign data_out   = valid ? held.val : '0;
    assign range_err  = valid & held.err;
    assign data_drive = ~hiz_req;

    assert_warm_bound_R7: assert property (@(posedge clk) disable iff (rst)
        warm_cnt <= CNT_W'(VALID_CYCLES));

    assert_valid_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        valid |=> valid);

    assert_quiet_before_valid_R7: assert property (@(posedge clk) disable iff (rst)
        !valid |-> (data_out == '0 && !range_err));

endmodule

// File: tb/adc_correct_backend_bench.sv
module adc_correct_backend_bench;

    localparam int NS    = 400;
    localparam int WARM  = 20;
    localparam int LAT   = 7;

    logic        clk = 1'b0;
    logic        rst;
    logic [17:0] stage_code;
    logic        fmt_twos;
    logic        hiz_req;
    logic [9:0]  data_out;
    logic        data_drive;
    logic        range_err;
    logic        valid;

    adc_correct_backend u_adc_correct_backend (
        .clk        (clk),
        .rst        (rst),
        .stage_code (stage_code),
        .fmt_twos   (fmt_twos),
        .hiz_req    (hiz_req),
        .data_out   (data_out),
        .data_drive (data_drive),
        .range_err  (range_err),
        .valid      (valid)
    );

    always #4 clk = ~clk;

    typedef struct {
        int due;
        int sum;
        bit err;
    } exp_t;

    exp_t        sb[$];
    logic [1:0]  hist [NS][9];
    int          checks   = 0;
    int          failures = 0;
    int          edge_cnt = 0;
    int          rel      = 0;
    bit          fmt_q1   = 0;
    bit          fmt_q2   = 0;
    bit          done     = 0;

    always @(posedge clk) begin
        edge_cnt <= edge_cnt + 1;
        rel      <= rst ? 0 : rel + 1;
        fmt_q1   <= fmt_twos;
        fmt_q2   <= fmt_q1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at edge %0d", req, act, exp, edge_cnt);
        end
    endtask

    function automatic void make_sample(input int t);
        for (int k = 0; k < 9; k++) begin
            int r;
            r = $urandom % 20;
            if (k == 8)      hist[t][k] = 2'($urandom % 4);
            else if (r == 0) hist[t][k] = 2'd3;
            else             hist[t][k] = 2'(r % 3);
        end
        // directed words R3: all-zero, all-max, alternating, lone illegal R4
        if (t == 30) for (int k = 0; k < 9; k++) hist[t][k] = 2'd0;
        if (t == 31) for (int k = 0; k < 9; k++) hist[t][k] = (k == 8) ? 2'd3 : 2'd2;
        if (t == 32) for (int k = 0; k < 9; k++) hist[t][k] = 2'(k % 2);
        if (t == 33) for (int k = 0; k < 9; k++) hist[t][k] = (k == 0) ? 2'd3 : 2'd0;
        if (t == 34) for (int k = 0; k < 9; k++) hist[t][k] = (k == 7) ? 2'd3 : 2'd1;
    endfunction

    function automatic exp_t model(input int t, input int due);
        exp_t e;
        e.due = due;
        e.sum = 0;
        e.err = 0;
        for (int k = 0; k < 8; k++) begin
            e.sum += ((hist[t][k] == 2'd3) ? 2 : int'(hist[t][k])) * (1 << (8 - k));
            if (hist[t][k] == 2'd3) e.err = 1;
        end
        e.sum += int'(hist[t][8]);
        return e;
    endfunction

    // driver
    initial begin
        rst = 1'b1; fmt_twos = 1'b0; hiz_req = 1'b0; stage_code = '0;
        repeat (3) @(negedge clk);
        // R8 reset state
        check(valid == 1'b0, "R8 valid in reset", int'(valid), 0);
        check(data_out == '0, "R8 data in reset", int'(data_out), 0);
        check(range_err == 1'b0, "R8 err in reset", int'(range_err), 0);
        rst = 1'b0;
        for (int t = 0; t < NS + 12; t++) begin
            if (t < NS) begin
                make_sample(t);
                sb.push_back(model(t, edge_cnt + 1 + LAT));
            end
            for (int k = 0; k < 9; k++) begin
                int s;
                s = t - k / 2;
                stage_code[2*k +: 2] = (s >= 0 && s < NS) ? hist[s][k] : 2'd0;
            end
            fmt_twos = ((t / 50) % 2) == 1 || (t >= 31 && t <= 40 && t % 2 == 1);
            hiz_req  = (t % 23) == 5;
            @(negedge clk);
        end
        repeat (10) @(negedge clk);
        check(sb.size() == 0, "R1 all results delivered", sb.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst) begin
                bit exp_valid;
                exp_valid = rel >= WARM;
                check(valid == exp_valid, "R7 valid flag", int'(valid), int'(exp_valid));
                check(data_drive == !hiz_req, "R6 drive enable", int'(data_drive), int'(!hiz_req));
                if (sb.size() > 0 && sb[0].due == edge_cnt) begin
                    exp_t e;
                    int   want;
                    bit   want_err;
                    e = sb.pop_front();
                    want     = exp_valid ? (e.sum ^ (fmt_q2 ? 512 : 0)) : 0;
                    want_err = exp_valid & e.err;
                    if (fmt_q2)
                        check(int'(data_out) == want, "R5 R1 R2 R3 two's complement result", int'(data_out), want);
                    else
                        check(int'(data_out) == want, "R1 R2 R3 offset binary result", int'(data_out), want);
                    check(range_err == want_err, "R4 illegal flag", int'(range_err), int'(want_err));
                end else if (sb.size() > 0 && sb[0].due < edge_cnt) begin
                    check(0, "R1 result missed", edge_cnt, sb[0].due);
                    void'(sb.pop_front());
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", edge_cnt, NS + 20);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule